// File: doc/BRIEF.md
# Selectable Pseudorandom Pattern Generator and Checker

This block is a link-test engine with two halves that share one pattern selector. The transmit half is a Fibonacci shift register. On every enabled clock it advances by a whole word of bits and presents that word on a registered output. The receive half takes words captured from the line and checks them. Each received bit is shifted straight into its own copy of the register. The two tap stages are XORed with the incoming bit to give a per-bit mismatch flag, so the checker aligns itself to the incoming stream without any seed exchange.

The number of mismatched bits is added into a saturating error counter that can be cleared. A lock flag reports a long run of clean words. After reset or a change of pattern, errors are not counted until the receive register has filled with bits of the new stream. A single-bit test input corrupts one generated word so that the whole path can be exercised in loopback.

Top module: `prbs_gen_chk`

## Requirements
- R1: After reset, genData is 0, errCount is 0 and locked is 0, and the generator register holds all ones, so the first generated word is the one that follows an all-ones seed.
- R2: With genEn high, each clock loads genData with the next WORD_W sequence bits, bit 0 earliest. For each bit the feedback f is the XOR of stage L-1 and stage k-1, the register shifts up with f entering stage 0, and the emitted bit is f. patSel code 0 selects x^7+x^6+1 (L=7, k=6) and code 1 selects x^9+x^5+1 (L=9, k=5); neither code inverts its output.
- R3: patSel code 2 selects x^15+x^14+1, code 3 selects x^23+x^18+1 and code 4 selects x^31+x^28+1. For these three codes every emitted bit is inverted.
- R4: With genEn low, genData and the generator register keep their values, and the next enabled word continues the sequence.
- R5: injectErr high in an enabled cycle inverts bit 0 of that generated word only. The generator register is not affected.
- R6: If the low L bits of the generator register are all zero when a step begins, the step starts from all ones.
- R7: For each valid received word (rxValid high), the checker removes the pattern inversion, forms per-bit mismatch flags from the feed-forward recurrence, and adds the number of qualified flags to errCount. A clean stream adds nothing. One flipped bit adds exactly 3.
- R8: A received bit is qualified only when at least L bits of the current pattern have been received before it, counting from reset or from the cycle in which patSel changed.
- R9: errCount saturates at its all-ones value and never wraps.
- R10: errClr high forces errCount to 0 on the next clock. It takes priority over errors arriving in the same cycle.
- R11: locked rises after LOCK_WORDS (64) consecutive received words that contain a qualified bit and no qualified error. It falls after any word with a qualified error and after any change of patSel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| patSel | input | 3 | Pattern code 0..4 (7, 9, 15, 23, 31 stage); codes 5..7 act as code 0 |
| genEn | input | 1 | Advance the generator by one word |
| injectErr | input | 1 | Invert bit 0 of the word generated this cycle |
| genData | output | WORD_W | Generated word, bit 0 first on the line |
| rxValid | input | 1 | rxData carries a received word |
| rxData | input | WORD_W | Received word, bit 0 first on the line |
| errClr | input | 1 | Clear the error counter |
| errCount | output | CNT_W | Saturating count of mismatched bits |
| locked | output | 1 | Checker is in lock |

## Verification
The assertions check on every cycle the properties that hold regardless of the data. The output word holds while the generator is disabled. The counter never decreases except through a clear, and a clear always empties it. A word with an error always drops lock, a pattern change always drops lock, and lock only rises on a clean checked word. The bench scenarios are needed for everything that depends on the sequence content. That covers the exact bit order and tap placement of all five polynomials, the inversion, and the recovery from an all-zero register. It also covers the exact count of three errors per flipped bit, the length of the suppression window, the 64-word lock delay and saturation at the top of the counter.

// File: rtl/prbs_pkg.sv
`timescale 1ns / 1ps
package prbs_pkg;

  // Widest supported register (31 stages).
  localparam int REG_W = 31;

  // Tap description: stage L-1, stage k-1, and output inversion.
  typedef struct packed {
    logic [4:0] lenIdx;
    logic [4:0] tapIdx;
    logic       invert;
  } tapInfo_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic       genStep;
    logic       chkStep;
    logic       clrErr;
    logic [5:0] filled;   // bits of the current pattern received before this word
  } ctlStrobe_t;

  function automatic tapInfo_t tapsFor(input logic [2:0] sel);
    tapInfo_t t;
    case (sel)
      3'd1:    t = '{lenIdx: 5'd8,  tapIdx: 5'd4,  invert: 1'b0};
      3'd2:    t = '{lenIdx: 5'd14, tapIdx: 5'd13, invert: 1'b1};
      3'd3:    t = '{lenIdx: 5'd22, tapIdx: 5'd17, invert: 1'b1};
      3'd4:    t = '{lenIdx: 5'd30, tapIdx: 5'd27, invert: 1'b1};
      default: t = '{lenIdx: 5'd6,  tapIdx: 5'd5,  invert: 1'b0};
    endcase
    return t;
  endfunction

endpackage

// File: rtl/prbs_lane.sv
`timescale 1ns / 1ps
// Word-parallel unrolled stepping of one shift register.
// FEED_FWD=0: feedback form, emitted bit is the feedback value.
// FEED_FWD=1: feed-forward form, received bits fill the register.
module prbs_lane
  import prbs_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter bit FEED_FWD = 1'b0
) (
  input  tapInfo_t          taps,
  input  logic [REG_W-1:0]  stateIn,
  input  logic [WORD_W-1:0] dataIn,
  output logic [REG_W-1:0]  stateOut,
  output logic [WORD_W-1:0] bitsOut
);

  generate
    if (FEED_FWD) begin : g_fwd
      logic [REG_W-1:0] s;
      logic             rxBit;
      always_comb begin
        s = stateIn;
        rxBit = 1'b0;
        for (int i = 0; i < WORD_W; i++) begin
          rxBit      = dataIn[i] ^ taps.invert;
          bitsOut[i] = rxBit ^ s[taps.lenIdx] ^ s[taps.tapIdx];
          s          = {s[REG_W-2:0], rxBit};
        end
        stateOut = s;
      end
    end else begin : g_back
      logic [REG_W-1:0] s;
      logic             fb;
      always_comb begin
        s = stateIn;
        fb = 1'b0;
        for (int i = 0; i < WORD_W; i++) begin
          fb         = s[taps.lenIdx] ^ s[taps.tapIdx] ^ dataIn[i];
          bitsOut[i] = fb ^ taps.invert;
          s          = {s[REG_W-2:0], fb};
        end
        stateOut = s;
      end
    end
  endgenerate

endmodule

// File: rtl/prbs_datapath.sv
`timescale 1ns / 1ps
module prbs_datapath
  import prbs_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  tapInfo_t          taps,
  input  logic              injectErr,
  input  logic [WORD_W-1:0] rxData,
  output logic [WORD_W-1:0] genData,
  output logic [CNT_W-1:0]  errCount,
  output logic              wordChecked,
  output logic              wordErr
);

  localparam int POP_W = $clog2(WORD_W + 1);

  logic [REG_W-1:0]  genState, genSeed, genNext, lenMask;
  logic [REG_W-1:0]  chkState, chkNext;
  logic [WORD_W-1:0] genBits, chkBits, qualMask, errBits;
  logic [POP_W-1:0]  errPop;
  logic [CNT_W:0]    cntSum;
  logic [31:0]       maskWide;

  // Active-length mask and all-zero recovery.
  always_comb begin
    maskWide = (32'd1 << ({1'b0, taps.lenIdx} + 6'd1)) - 32'd1;
    lenMask  = maskWide[REG_W-1:0];
    genSeed  = ((genState & lenMask) == '0) ? '1 : genState;
  end

  prbs_lane #(.WORD_W(WORD_W), .FEED_FWD(1'b0)) u_genLane (
    .taps    (taps),
    .stateIn (genSeed),
    .dataIn  ({WORD_W{1'b0}}),
    .stateOut(genNext),
    .bitsOut (genBits)
  );

  prbs_lane #(.WORD_W(WORD_W), .FEED_FWD(1'b1)) u_chkLane (
    .taps    (taps),
    .stateIn (chkState),
    .dataIn  (rxData),
    .stateOut(chkNext),
    .bitsOut (chkBits)
  );

  // A bit is qualified once L bits of this pattern precede it.
  generate
    for (genvar i = 0; i < WORD_W; i++) begin : g_qual
      assign qualMask[i] = (16'(ctl.filled) + 16'(i)) > 16'(taps.lenIdx);
    end
  endgenerate

  assign errBits     = chkBits & qualMask;
  assign wordChecked = ctl.chkStep & (|qualMask);
  assign wordErr     = ctl.chkStep & (|errBits);

  always_comb begin
    errPop = '0;
    for (int i = 0; i < WORD_W; i++) errPop = errPop + POP_W'(errBits[i]);
    cntSum = {1'b0, errCount} + (CNT_W + 1)'(errPop);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genState <= '1;
      genData  <= '0;
    end else if (ctl.genStep) begin
      genState <= genNext;
      genData  <= genBits ^ {{(WORD_W - 1){1'b0}}, injectErr};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chkState <= '0;
    else if (ctl.chkStep) chkState <= chkNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errCount <= '0;
    else if (ctl.clrErr) errCount <= '0;
    else if (ctl.chkStep) errCount <= cntSum[CNT_W] ? '1 : cntSum[CNT_W-1:0];
  end

endmodule

// File: rtl/prbs_control.sv
`timescale 1ns / 1ps
module prbs_control
  import prbs_pkg::*;
#(
  parameter int WORD_W     = 8,
  parameter int LOCK_WORDS = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] patSel,
  input  logic       genEn,
  input  logic       rxValid,
  input  logic       errClr,
  input  logic       wordChecked,
  input  logic       wordErr,
  output ctlStrobe_t ctl,
  output tapInfo_t   taps,
  output logic       locked
);

  localparam int RUN_W    = $clog2(LOCK_WORDS + 1);
  localparam int FILL_MAX = 63;

  logic [2:0]       prevSel;
  logic             selChanged;
  logic [5:0]       fill, effFill, fillNext;
  logic [RUN_W-1:0] runCnt;
  int               fillSum;

  always_comb begin
    selChanged = (patSel != prevSel);
    effFill    = selChanged ? 6'd0 : fill;
    fillSum    = int'(effFill) + WORD_W;
    fillNext   = (fillSum > FILL_MAX) ? 6'(FILL_MAX) : 6'(fillSum);
    taps       = tapsFor(patSel);
    ctl.genStep = genEn;
    ctl.chkStep = rxValid;
    ctl.clrErr  = errClr;
    ctl.filled  = effFill;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSel <= '0;
      fill    <= '0;
    end else begin
      prevSel <= patSel;
      fill    <= rxValid ? fillNext : effFill;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
      locked <= 1'b0;
    end else if (selChanged || wordErr) begin
      runCnt <= '0;
      locked <= 1'b0;
    end else if (wordChecked) begin
      if (runCnt < RUN_W'(LOCK_WORDS)) runCnt <= runCnt + 1'b1;
      if (runCnt >= RUN_W'(LOCK_WORDS - 1)) locked <= 1'b1;
    end
  end

endmodule

// File: rtl/prbs_gen_chk.sv
`timescale 1ns / 1ps
module prbs_gen_chk
  import prbs_pkg::*;
#(
  parameter int WORD_W     = 8,
  parameter int CNT_W      = 16,
  parameter int LOCK_WORDS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        patSel,
  input  logic              genEn,
  input  logic              injectErr,
  output logic [WORD_W-1:0] genData,
  input  logic              rxValid,
  input  logic [WORD_W-1:0] rxData,
  input  logic              errClr,
  output logic [CNT_W-1:0]  errCount,
  output logic              locked
);

  ctlStrobe_t ctl;
  tapInfo_t   taps;
  logic       wordChecked;
  logic       wordErr;

  prbs_control #(.WORD_W(WORD_W), .LOCK_WORDS(LOCK_WORDS)) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .patSel     (patSel),
    .genEn      (genEn),
    .rxValid    (rxValid),
    .errClr     (errClr),
    .wordChecked(wordChecked),
    .wordErr    (wordErr),
    .ctl        (ctl),
    .taps       (taps),
    .locked     (locked)
  );

  prbs_datapath #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .taps       (taps),
    .injectErr  (injectErr),
    .rxData     (rxData),
    .genData    (genData),
    .errCount   (errCount),
    .wordChecked(wordChecked),
    .wordErr    (wordErr)
  );

endmodule

// File: rtl/prbs_gen_chk_sva.sv
`timescale 1ns / 1ps
module prbs_gen_chk_sva #(
  parameter int WORD_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        patSel,
  input logic              genEn,
  input logic [WORD_W-1:0] genData,
  input logic              rxValid,
  input logic              errClr,
  input logic [CNT_W-1:0]  errCount,
  input logic              locked,
  input logic              wordChecked,
  input logic              wordErr
);

  a_r4_hold_word: assert property (@(posedge clk) disable iff (!rstN)
    !genEn |=> $stable(genData));

  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    !errClr |=> errCount >= $past(errCount));

  a_r10_clear: assert property (@(posedge clk) disable iff (!rstN)
    errClr |=> errCount == '0);

  a_r7_err_needs_word: assert property (@(posedge clk) disable iff (!rstN)
    wordErr |-> rxValid);

  a_r11_drop_on_err: assert property (@(posedge clk) disable iff (!rstN)
    wordErr |=> !locked);

  a_r11_drop_on_sel: assert property (@(posedge clk) disable iff (!rstN)
    (patSel != $past(patSel)) |=> !locked);

  a_r11_rise_clean: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(wordChecked && !wordErr));

endmodule

bind prbs_gen_chk prbs_gen_chk_sva #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_sva (
  .clk        (clk),
  .rstN       (rstN),
  .patSel     (patSel),
  .genEn      (genEn),
  .genData    (genData),
  .rxValid    (rxValid),
  .errClr     (errClr),
  .errCount   (errCount),
  .locked     (locked),
  .wordChecked(wordChecked),
  .wordErr    (wordErr)
);

// File: tb/test_prbs_gen_chk.sv
`timescale 1ns / 1ps
module test_prbs_gen_chk;

  localparam int W  = 8;
  localparam int CW = 12;
  localparam int LW = 64;

  logic          clk = 1'b0;
  logic          rstN;
  logic [2:0]    patSel;
  logic          genEn, injectErr, rxValid, errClr;
  logic [W-1:0]  genData, rxData;
  logic [CW-1:0] errCount;
  logic          locked;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  prbs_gen_chk #(.WORD_W(W), .CNT_W(CW), .LOCK_WORDS(LW)) i_prbs_gen_chk (
    .clk(clk), .rstN(rstN), .patSel(patSel), .genEn(genEn), .injectErr(injectErr),
    .genData(genData), .rxValid(rxValid), .rxData(rxData), .errClr(errClr),
    .errCount(errCount), .locked(locked)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lenOf(input logic [2:0] sel);
    case (sel)
      3'd1: return 9;
      3'd2: return 15;
      3'd3: return 23;
      3'd4: return 31;
      default: return 7;
    endcase
  endfunction

  // Serial reference of the recurrence stated in R2, R3 and R6.
  task automatic modelWord(input logic [2:0] sel, inout logic [30:0] st, output logic [W-1:0] w);
    int L, k;
    bit inv, fb;
    logic [31:0] mask;
    L = lenOf(sel);
    case (sel)
      3'd1: begin k = 5;  inv = 0; end
      3'd2: begin k = 14; inv = 1; end
      3'd3: begin k = 18; inv = 1; end
      3'd4: begin k = 28; inv = 1; end
      default: begin k = 6; inv = 0; end
    endcase
    mask = (32'd1 << L) - 32'd1;
    if ((st & mask[30:0]) == 31'd0) st = '1;
    for (int i = 0; i < W; i++) begin
      fb   = st[L-1] ^ st[k-1];
      w[i] = fb ^ inv;
      st   = {st[29:0], fb};
    end
  endtask

  task automatic doReset(input logic [2:0] sel);
    rstN = 1'b0; patSel = sel; genEn = 0; injectErr = 0; rxValid = 0; rxData = '0; errClr = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic feedRx(input logic [W-1:0] w);
    rxValid = 1'b1;
    rxData  = w;
    @(negedge clk);
  endtask

  // Feed a clean stream until nNeed checked words have passed; lock must appear only then.
  task automatic runToLock(input logic [2:0] sel, inout logic [30:0] st, input int fillStart,
                           input int nNeed, input string tag);
    logic [W-1:0] w;
    int fillB, nChk, L, idx;
    logic [CW-1:0] base;
    base = errCount; fillB = fillStart; nChk = 0; idx = 0; L = lenOf(sel);
    patSel = sel;
    while (nChk < nNeed) begin
      modelWord(sel, st, w);
      feedRx(w);
      if (fillB + W - 1 >= L) nChk++;
      fillB = (fillB + W > 63) ? 63 : fillB + W;
      if (idx == 0 && nNeed > 1) check(!locked, {tag, " R11 no lock after first word"}, locked, 0);
      if (nChk == nNeed - 1 && fillB + W - 1 >= L)
        check(!locked, {tag, " R11 not yet locked one word early"}, locked, 0);
      idx++;
    end
    rxValid = 1'b0;
    check(locked, {tag, " R11 locked after run"}, locked, 1);
    check(errCount == base, {tag, " R8 clean stream adds no errors"}, errCount, base);
  endtask

  task automatic t_reset();
    doReset(3'd0);
    check(genData == '0, "R1 genData after reset", genData, 0);
    check(errCount == '0, "R1 errCount after reset", errCount, 0);
    check(!locked, "R1 locked after reset", locked, 0);
  endtask

  task automatic t_gen(input logic [2:0] sel, input int n, input string tag);
    logic [30:0] st;
    logic [W-1:0] w;
    int bad;
    doReset(sel);
    st = '1; bad = 0;
    for (int j = 0; j < n; j++) begin
      genEn = 1'b1;
      @(negedge clk);
      modelWord(sel, st, w);
      if (genData != w) begin
        bad++;
        check(0, {tag, " word mismatch"}, genData, w);
      end
    end
    genEn = 1'b0;
    check(bad == 0, {tag, " sequence from all-ones seed (R1)"}, bad, 0);
  endtask

  task automatic t_holdInject();
    logic [30:0] st;
    logic [W-1:0] w, held;
    doReset(3'd0);
    st = '1;
    repeat (3) begin genEn = 1; @(negedge clk); modelWord(0, st, w); end
    held = genData;
    genEn = 0;
    repeat (5) @(negedge clk);
    check(genData == held, "R4 genData holds while disabled", genData, held);
    genEn = 1; @(negedge clk); modelWord(0, st, w);
    check(genData == w, "R4 sequence resumes after hold", genData, w);
    injectErr = 1; @(negedge clk); modelWord(0, st, w);
    injectErr = 0;
    check(genData == (w ^ 8'h01), "R5 injected word has bit 0 inverted", genData, w ^ 8'h01);
    @(negedge clk); modelWord(0, st, w);
    genEn = 0;
    check(genData == w, "R5 state unaffected by injection", genData, w);
  endtask

  task automatic t_zeroRecover();
    logic [30:0] st;
    logic [W-1:0] w;
    int bad, j;
    bit found;
    doReset(3'd4);
    st = '1; bad = 0; found = 0; j = 0;
    while (!found && j < 20000) begin
      genEn = 1; @(negedge clk); modelWord(4, st, w);
      if (genData != w) bad++;
      if (st[6:0] == 7'd0) found = 1;
      j++;
    end
    check(bad == 0, "R3 31-stage inverted sequence", bad, 0);
    check(found, "R6 reached low seven stages all zero", found, 1);
    patSel = 3'd0;
    @(negedge clk); modelWord(0, st, w);
    genEn = 0;
    check(genData == w, "R6 restart from all ones", genData, w);
  endtask

  task automatic t_checker();
    logic [30:0] st, st9;
    logic [W-1:0] w;
    doReset(3'd0);
    st = 31'h1234567;
    repeat (13) modelWord(0, st, w);
    runToLock(0, st, 0, LW, "initial");
    // one flipped bit: errors at the bit and at both tap distances
    modelWord(0, st, w); feedRx(w ^ 8'h08);
    check(!locked, "R11 lock drops on error word", locked, 0);
    modelWord(0, st, w); feedRx(w);
    modelWord(0, st, w); feedRx(w);
    rxValid = 0;
    check(errCount == 3, "R7 one flipped bit counts three", errCount, 3);
    runToLock(0, st, 63, LW - 1, "relock");
    // clear priority over arriving errors
    errClr = 1; modelWord(0, st, w); feedRx(w ^ 8'h10);
    errClr = 0;
    check(errCount == 0, "R10 clear wins over same-cycle errors", errCount, 0);
    modelWord(0, st, w); feedRx(w);
    rxValid = 0;
    check(errCount != 0, "R7 later taps still see corrupted bit", errCount, 2);
    errClr = 1; @(negedge clk); errClr = 0;
    check(errCount == 0, "R10 clear alone", errCount, 0);
    // pattern change to 9 stages, stream joined mid-sequence
    repeat (70) begin modelWord(0, st, w); feedRx(w); end
    check(locked, "R11 relocked before pattern change", locked, 1);
    st9 = 31'h0ABCDEF;
    repeat (5) modelWord(1, st9, w);
    runToLock(1, st9, 0, LW, "patchange");
  endtask

  task automatic t_loopback();
    int c;
    doReset(3'd2);
    for (c = 0; c < 200; c++) begin
      genEn = 1; rxValid = (c > 0); rxData = genData; injectErr = (c == 100);
      @(negedge clk);
      if (c == 95) begin
        check(locked, "R11 loopback locked", locked, 1);
        check(errCount == 0, "R7 loopback clean", errCount, 0);
      end
    end
    genEn = 0; rxValid = 0; injectErr = 0;
    check(errCount == 3, "R5 injected bit seen as three errors (R7)", errCount, 3);
    check(locked, "R11 loopback relocked", locked, 1);
  endtask

  task automatic t_saturate();
    doReset(3'd0);
    repeat (1500) feedRx(8'h0F);
    check(errCount == {CW{1'b1}}, "R9 counter saturates", errCount, {CW{1'b1}});
    repeat (10) feedRx(8'h0F);
    rxValid = 0;
    check(errCount == {CW{1'b1}}, "R9 counter stays saturated", errCount, {CW{1'b1}});
    check(!locked, "R11 no lock on erroneous stream", locked, 0);
  endtask

  initial begin
    #(150000 * 5);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_gen(3'd0, 40, "R2 7-stage");
    t_gen(3'd1, 40, "R2 9-stage");
    t_gen(3'd2, 40, "R3 15-stage");
    t_gen(3'd3, 40, "R3 23-stage");
    t_gen(3'd4, 40, "R3 31-stage");
    t_holdInject();
    t_zeroRecover();
    t_checker();
    t_loopback();
    t_saturate();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule